// File: doc/BRIEF.md
# Reverse-channel parallel port receiver with run-length expansion

This block sits on the host side of an IEEE 1284 parallel port that is already in ECP mode and pulls bytes from the peripheral. A read request carries a byte count. If the port still drives the data lines, the block first turns the bus around. It then takes bytes from the peripheral one handshake at a time and sorts each byte by the state of Busy when nAck fell. A data byte goes out on a valid/ready stream. A command byte either sets a run length or names a channel. Channel commands are dropped.

A run-length command makes the next data byte appear on the stream once and then the given number of extra times. The extra copies come from an internal register and cause no bus cycles. The request count also limits the repeats. Any copies left over are delivered at the start of the next request, before the block reads the bus again. The per-byte acknowledge on nAutoFd is held back while the stream is stalled, so the peripheral cannot run ahead of the consumer. All peripheral inputs are taken to be synchronous to `clk_i`. One tick is `TICK_CYC` clock cycles.

Top module: `ecp_rev_rx`

## Requirements
- R1: After reset: dir_in_o=0, n_autofd_o=1, n_strobe_o=1, n_init_o=1, n_selectin_o=0, out_valid_o=0 and done_o=0.
- R2: On a request while dir_in_o=0, the block sets dir_in_o=1 and n_autofd_o=0 together, with n_init_o still 1. No less than one tick later it drives n_init_o=0, n_strobe_o=1 and n_selectin_o=1.
- R3: If perror_i has not gone low within 6 ticks of n_init_o falling, done_o pulses with err_o=1 and done_cnt_o=0, and every control pin returns to its R1 value.
- R4: A byte seen while n_ack_i=0 and busy_i=1 is a data byte and is presented unchanged on out_data_o.
- R5: After each bus byte is taken, n_autofd_o goes to 1, and it returns to 0 once n_ack_i=1. If n_ack_i stays 0 for 6 ticks, done_o pulses with err_o=1.
- R6: If n_ack_i does not fall within 2000 ticks while a byte is awaited, done_o pulses with err_o=0 and done_cnt_o equal to the number of bytes delivered so far.
- R7: A byte seen with busy_i=0 and bit 7 = 1 is a channel command. It is acknowledged and produces no output.
- R8: A byte seen with busy_i=0 and bit 7 = 0 sets a run length N (bits 6:0). The next data byte is output 1+N times.
- R9: The request count limits the repeats. Repeats left over are output first on the next request, with no bus handshake and n_autofd_o held at 0.
- R10: While out_valid_o=1 and out_ready_i=0, out_valid_o and out_data_o hold and n_autofd_o stays 0.
- R11: A request while dir_in_o=1 skips the turnaround, and n_init_o stays 0.
- R12: When the requested count has been delivered, done_o pulses for one cycle with err_o=0 and done_cnt_o equal to the request count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start a read request (taken when idle) |
| req_len_i | input | CNT_W | Bytes requested |
| pd_i | input | 8 | Parallel data lines |
| n_ack_i | input | 1 | Peripheral strobe, active low |
| busy_i | input | 1 | High = data byte, low = command byte |
| perror_i | input | 1 | Low once the peripheral owns the bus |
| dir_in_o | output | 1 | Data line direction, 1 = input |
| n_autofd_o | output | 1 | Host acknowledge |
| n_strobe_o | output | 1 | Host strobe |
| n_init_o | output | 1 | Reverse request, active low |
| n_selectin_o | output | 1 | Select-in line |
| out_data_o | output | 8 | Output byte |
| out_valid_o | output | 1 | Output byte valid |
| out_ready_i | input | 1 | Consumer ready |
| done_o | output | 1 | One-cycle end-of-request pulse |
| err_o | output | 1 | Request ended on a protocol timeout (valid with done_o) |
| done_cnt_o | output | CNT_W | Bytes delivered by the request |

## Verification
A corrupted run-length counter or pending flag shows up on the stream within a few cycles: there are too many or too few copies of the repeated byte, or a repeat appears where a fresh bus byte was due. The scoreboard reports it at the first wrong item. A wrong handshake state shows up on n_autofd_o within one handshake. Either the peripheral model waits for an acknowledge edge that never comes, or the block acknowledges while its output is stalled. Turnaround and timeout faults show up as a wrong err_o or done_cnt_o at the next done_o pulse.

// File: rtl/ecp_rx_pkg.sv
package ecp_rx_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_TSET, S_TPE, S_RUN, S_REP, S_WACK, S_OUT, S_ACKH, S_DONE
  } rx_state_e;

  typedef struct packed {
    logic dir_in;
    logic n_autofd;
    logic n_strobe;
    logic n_init;
    logic n_selectin;
  } pin_ctl_t;

  localparam pin_ctl_t CTL_IDLE = '{dir_in: 1'b0, n_autofd: 1'b1, n_strobe: 1'b1,
                                    n_init: 1'b1, n_selectin: 1'b0};

endpackage

// File: rtl/ecp_tick_timer.sv
module ecp_tick_timer #(
  parameter int TICK_CYC = 4,
  parameter int LIM_W    = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic [LIM_W-1:0] limit_i,
  output logic             expired_o
);
  localparam int PRE_W = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_CYC - 1);

  logic [PRE_W-1:0] pre_q;
  logic [LIM_W-1:0] ticks_q;

  assign expired_o = (ticks_q >= limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q   <= '0;
      ticks_q <= '0;
    end else if (restart_i) begin
      pre_q   <= '0;
      ticks_q <= '0;
    end else if (!expired_o) begin
      if (pre_q == PRE_LAST) begin
        pre_q   <= '0;
        ticks_q <= ticks_q + 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  // R6: the tick count never passes the active window
  a_r6_tick_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !restart_i |-> ticks_q <= limit_i);

endmodule

// File: rtl/ecp_rle_store.sv
module ecp_rle_store (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic [6:0] load_cnt_i,
  input  logic       seen_i,
  input  logic [7:0] seen_byte_i,
  input  logic       take_i,
  output logic       pending_o,
  output logic [7:0] rep_byte_o
);
  logic [6:0] rep_cnt_q;
  logic       armed_q;

  assign pending_o = !armed_q && (rep_cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rep_cnt_q  <= '0;
      armed_q    <= 1'b0;
      rep_byte_o <= '0;
    end else begin
      if (load_i) begin
        rep_cnt_q <= load_cnt_i;
        armed_q   <= 1'b1;
      end else if (take_i) begin
        rep_cnt_q <= rep_cnt_q - 1'b1;
      end
      if (seen_i && armed_q) begin
        rep_byte_o <= seen_byte_i;
        armed_q    <= 1'b0;
      end
    end
  end

  // R8: a copy is only taken while one is owed
  a_r8_take_owed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> pending_o);
  // R9: owed copies are drained before a new count is loaded
  a_r9_no_overwrite: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !pending_o);

endmodule

// File: rtl/ecp_rev_rx.sv
module ecp_rev_rx
  import ecp_rx_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int TICK_CYC    = 4,
  parameter int SETUP_TICKS = 1,
  parameter int RESP_TICKS  = 6,
  parameter int IDLE_TICKS  = 2000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [CNT_W-1:0] req_len_i,
  input  logic [7:0]       pd_i,
  input  logic             n_ack_i,
  input  logic             busy_i,
  input  logic             perror_i,
  output logic             dir_in_o,
  output logic             n_autofd_o,
  output logic             n_strobe_o,
  output logic             n_init_o,
  output logic             n_selectin_o,
  output logic [7:0]       out_data_o,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic             done_o,
  output logic             err_o,
  output logic [CNT_W-1:0] done_cnt_o
);
  localparam int LIM_W = $clog2(IDLE_TICKS + 1);
  localparam logic [LIM_W-1:0] LIM_SETUP = LIM_W'(SETUP_TICKS);
  localparam logic [LIM_W-1:0] LIM_RESP  = LIM_W'(RESP_TICKS);
  localparam logic [LIM_W-1:0] LIM_IDLE  = LIM_W'(IDLE_TICKS);

  rx_state_e        state_q, state_d;
  pin_ctl_t         ctl_q, ctl_d;
  logic [CNT_W-1:0] rem_q, rem_d, cnt_q, cnt_d;
  logic [7:0]       byte_q, byte_d;
  logic             err_q, err_d;
  logic [LIM_W-1:0] lim;
  logic             expired, rle_load, rle_seen, rle_take, rle_pend;
  logic [7:0]       rle_byte;

  ecp_tick_timer #(.TICK_CYC(TICK_CYC), .LIM_W(LIM_W)) u_tmr (
    .clk_i, .rst_ni, .restart_i(state_d != state_q), .limit_i(lim), .expired_o(expired));

  ecp_rle_store u_rle (
    .clk_i, .rst_ni, .load_i(rle_load), .load_cnt_i(byte_d[6:0]),
    .seen_i(rle_seen), .seen_byte_i(byte_q), .take_i(rle_take),
    .pending_o(rle_pend), .rep_byte_o(rle_byte));

  always_comb begin
    state_d  = state_q;
    ctl_d    = ctl_q;
    rem_d    = rem_q;
    cnt_d    = cnt_q;
    byte_d   = byte_q;
    err_d    = err_q;
    lim      = LIM_RESP;
    rle_load = 1'b0;
    rle_seen = 1'b0;
    rle_take = 1'b0;
    unique case (state_q)
      S_IDLE: if (req_i) begin
        rem_d = req_len_i;
        cnt_d = '0;
        err_d = 1'b0;
        if (!ctl_q.dir_in) begin
          ctl_d.dir_in   = 1'b1;
          ctl_d.n_autofd = 1'b0;
          state_d        = S_TSET;
        end else begin
          state_d = S_RUN;
        end
      end
      S_TSET: begin
        lim = LIM_SETUP;
        if (expired) begin
          ctl_d.n_init     = 1'b0;
          ctl_d.n_strobe   = 1'b1;
          ctl_d.n_selectin = 1'b1;
          state_d          = S_TPE;
        end
      end
      S_TPE: begin
        if (!perror_i) state_d = S_RUN;
        else if (expired) begin
          ctl_d   = CTL_IDLE;
          err_d   = 1'b1;
          state_d = S_DONE;
        end
      end
      S_RUN: begin
        if (rem_q == '0)  state_d = S_DONE;
        else if (rle_pend) state_d = S_REP;
        else               state_d = S_WACK;
      end
      S_REP: if (out_ready_i) begin
        rle_take = 1'b1;
        rem_d    = rem_q - 1'b1;
        cnt_d    = cnt_q + 1'b1;
        state_d  = S_RUN;
      end
      S_WACK: begin
        lim = LIM_IDLE;
        if (!n_ack_i) begin
          byte_d = pd_i;
          if (busy_i) state_d = S_OUT;
          else begin
            rle_load       = !pd_i[7];  // channel commands are dropped
            ctl_d.n_autofd = 1'b1;
            state_d        = S_ACKH;
          end
        end else if (expired) begin
          state_d = S_DONE;
        end
      end
      S_OUT: if (out_ready_i) begin
        rle_seen       = 1'b1;
        rem_d          = rem_q - 1'b1;
        cnt_d          = cnt_q + 1'b1;
        ctl_d.n_autofd = 1'b1;
        state_d        = S_ACKH;
      end
      S_ACKH: begin
        if (n_ack_i) begin
          ctl_d.n_autofd = 1'b0;
          state_d        = S_RUN;
        end else if (expired) begin
          ctl_d.n_autofd = 1'b0;
          err_d          = 1'b1;
          state_d        = S_DONE;
        end
      end
      S_DONE:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      ctl_q   <= CTL_IDLE;
      rem_q   <= '0;
      cnt_q   <= '0;
      byte_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ctl_q   <= ctl_d;
      rem_q   <= rem_d;
      cnt_q   <= cnt_d;
      byte_q  <= byte_d;
      err_q   <= err_d;
    end
  end

  assign dir_in_o     = ctl_q.dir_in;
  assign n_autofd_o   = ctl_q.n_autofd;
  assign n_strobe_o   = ctl_q.n_strobe;
  assign n_init_o     = ctl_q.n_init;
  assign n_selectin_o = ctl_q.n_selectin;
  assign out_valid_o  = (state_q == S_REP) || (state_q == S_OUT);
  assign out_data_o   = (state_q == S_REP) ? rle_byte : byte_q;
  assign done_o       = (state_q == S_DONE);
  assign err_o        = err_q;
  assign done_cnt_o   = cnt_q;

  // R10: a stalled byte is held
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));
  // R10: no acknowledge while a byte is offered
  a_r10_ack_withheld: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !n_autofd_o);
  // R2: reverse request only with the data lines set to input
  a_r2_init_needs_input: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !n_init_o |-> dir_in_o);
  // R12: completion is a single-cycle pulse
  a_r12_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

endmodule

// File: tb/sim_ecp_rev_rx.sv
module sim_ecp_rev_rx;
  localparam int CNT_W = 16;
  localparam int TICK_CYC = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0;
  logic [CNT_W-1:0] req_len = '0;
  logic [7:0] pd = '0;
  logic n_ack = 1'b1, busy = 1'b1, perror = 1'b1, rdy = 1'b1;
  logic dir_in, n_autofd, n_strobe, n_init, n_selectin, out_valid, done, err;
  logic [7:0] out_data;
  logic [CNT_W-1:0] done_cnt;

  int n_chk = 0, n_fail = 0, n_pop = 0, stall_left = 0, cyc = 0;
  logic [7:0] exp_q[$];
  logic prev_stall = 1'b0;
  logic [7:0] prev_data = '0;
  int got_cnt, got_err;

  always #2.5 clk = ~clk;

  ecp_rev_rx #(.CNT_W(CNT_W), .TICK_CYC(TICK_CYC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .req_len_i(req_len), .pd_i(pd),
    .n_ack_i(n_ack), .busy_i(busy), .perror_i(perror), .dir_in_o(dir_in),
    .n_autofd_o(n_autofd), .n_strobe_o(n_strobe), .n_init_o(n_init),
    .n_selectin_o(n_selectin), .out_data_o(out_data), .out_valid_o(out_valid),
    .out_ready_i(rdy), .done_o(done), .err_o(err), .done_cnt_o(done_cnt));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // ready driver
  always @(posedge clk) begin
    #1;
    if (stall_left > 0) begin rdy <= 1'b0; stall_left = stall_left - 1; end
    else rdy <= 1'b1;
  end

  // scoreboard monitor
  always @(negedge clk) if (rst_n) begin
    if (prev_stall) begin
      chk(out_valid && out_data == prev_data, "R10 hold", int'(out_data), int'(prev_data));
    end
    prev_stall = out_valid && !rdy;
    prev_data  = out_data;
    if (out_valid && !rdy) chk(!n_autofd, "R10 ack held low", int'(n_autofd), 0);
    if (out_valid && rdy) begin
      n_pop++;
      if (exp_q.size() == 0) chk(1'b0, "R4 unexpected byte", int'(out_data), -1);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(out_data == e, "R4/R8 stream byte", int'(out_data), int'(e));
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic start(input int len);
    @(negedge clk); req = 1'b1; req_len = CNT_W'(len);
    @(negedge clk); req = 1'b0;
  endtask

  task automatic wait_done();
    int i;
    for (i = 0; i < 20000 && !done; i++) @(negedge clk);
    got_cnt = int'(done_cnt); got_err = int'(err);
    @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b, input logic bz, input bit raise);
    int i;
    @(negedge clk); pd = b; busy = bz;
    @(negedge clk); n_ack = 1'b0;
    for (i = 0; i < 5000 && !n_autofd; i++) @(negedge clk);
    chk(n_autofd, "R5 acknowledge rises", int'(n_autofd), 1);
    if (raise) begin
      n_ack = 1'b1;
      for (i = 0; i < 50 && n_autofd; i++) @(negedge clk);
      chk(!n_autofd, "R5 acknowledge returns low", int'(n_autofd), 0);
    end
  endtask

  initial begin
    int i, t;
    repeat (3) @(negedge clk);
    // R1
    chk({dir_in, n_autofd, n_strobe, n_init, n_selectin} == 5'b01110,
        "R1 reset pins", int'({dir_in, n_autofd, n_strobe, n_init, n_selectin}), 'b01110);
    chk(!out_valid && !done, "R1 reset outputs", int'({out_valid, done}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 / R3: turnaround with no peripheral response
    start(4);
    for (i = 0; i < 20 && !dir_in; i++) @(negedge clk);
    chk(dir_in && !n_autofd && n_init, "R2 turn first step",
        int'({dir_in, n_autofd, n_init}), 'b101);
    t = 0;
    while (n_init && t < 100) begin @(negedge clk); t++; end
    chk(t >= TICK_CYC, "R2 setup tick", t, TICK_CYC);
    chk(!n_init && n_strobe && n_selectin, "R2 reverse pins",
        int'({n_init, n_strobe, n_selectin}), 'b011);
    t = 0;
    while (!done && t < 200) begin @(negedge clk); t++; end
    chk(t >= 6 * TICK_CYC, "R3 response window", t, 6 * TICK_CYC);
    chk(err && done_cnt == 0, "R3 timeout status", int'({err, done_cnt}), 'h10000);
    @(negedge clk);
    chk({dir_in, n_autofd, n_strobe, n_init, n_selectin} == 5'b01110,
        "R3 pins restored", int'({dir_in, n_autofd, n_strobe, n_init, n_selectin}), 'b01110);

    // R4 / R12: turnaround succeeds, three data bytes, one stalled
    start(3);
    for (i = 0; i < 100 && n_init; i++) @(negedge clk);
    perror = 1'b0;
    exp_q.push_back(8'hA1); send(8'hA1, 1'b1, 1);
    exp_q.push_back(8'hB2); stall_left = 6; send(8'hB2, 1'b1, 1);
    exp_q.push_back(8'hC3); send(8'hC3, 1'b1, 1);
    wait_done();
    chk(got_err == 0 && got_cnt == 3, "R12 count reached", got_cnt, 3);
    chk(exp_q.size() == 0, "R4 all delivered", exp_q.size(), 0);

    // R11 / R7 / R8
    start(5);
    repeat (3) @(negedge clk);
    chk(dir_in && !n_init, "R11 no second turnaround", int'({dir_in, n_init}), 'b10);
    t = n_pop;
    send(8'h85, 1'b0, 1);
    repeat (2) @(negedge clk);
    chk(n_pop == t, "R7 channel command dropped", n_pop, t);
    send(8'h02, 1'b0, 1);
    repeat (3) exp_q.push_back(8'h5A);
    send(8'h5A, 1'b1, 1);
    exp_q.push_back(8'h11); send(8'h11, 1'b1, 1);
    exp_q.push_back(8'h22); send(8'h22, 1'b1, 1);
    wait_done();
    chk(got_err == 0 && got_cnt == 5, "R8 run expanded", got_cnt, 5);
    chk(exp_q.size() == 0, "R8 stream complete", exp_q.size(), 0);

    // R9: repeats limited and carried over
    start(2);
    send(8'h04, 1'b0, 1);
    exp_q.push_back(8'h77); exp_q.push_back(8'h77);
    send(8'h77, 1'b1, 1);
    wait_done();
    chk(got_cnt == 2, "R9 repeats clipped", got_cnt, 2);
    exp_q.push_back(8'h77); exp_q.push_back(8'h77);
    start(2);
    t = 0;
    while (!done && t < 40) begin
      @(negedge clk); t++;
      if (n_autofd) chk(1'b0, "R9 no bus handshake", 1, 0);
    end
    chk(done && done_cnt == 2 && t < 40, "R9 leftover drained", int'(done_cnt), 2);
    @(negedge clk);
    exp_q.push_back(8'h77);
    start(3);
    exp_q.push_back(8'h33); send(8'h33, 1'b1, 1);
    exp_q.push_back(8'h44); send(8'h44, 1'b1, 1);
    wait_done();
    chk(got_cnt == 3 && exp_q.size() == 0, "R9 last repeat then bus", got_cnt, 3);

    // R6: idle timeout
    start(4);
    exp_q.push_back(8'h99); send(8'h99, 1'b1, 1);
    wait_done();
    chk(got_err == 0 && got_cnt == 1, "R6 idle end", got_cnt * 2 + got_err, 2);

    // R5: acknowledge timeout
    start(2);
    exp_q.push_back(8'hE7); send(8'hE7, 1'b1, 0);
    wait_done();
    chk(got_err == 1 && got_cnt == 1, "R5 ack timeout", got_cnt * 2 + got_err, 3);
    n_ack = 1'b1;
    chk(exp_q.size() == 0, "R4 scoreboard empty", exp_q.size(), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule